// File: doc/BRIEF.md
# Two-Phase Elastic Handshake Pipeline

This block is a clocked model of a transition-signalled elastic pipeline. A producer on the left toggles `req_in` to offer an event. The block toggles `ack_in` once it has taken that event. On the right, the block toggles `req_out` to present the oldest stored event, and a consumer toggles `ack_out` to accept it. Each level change on a handshake wire, rising or falling, is one event. The block therefore acts as a FIFO of request events with `STAGES` slots.

Each slot is a Muller C-element. Its inputs are the output of the previous stage and the inverted output of the next stage. Its output is the request it passes forward and the acknowledge it sends back. All stage outputs are registered from the values they had in the previous cycle, so an event moves at most one stage per clock. The external `req_in` and `ack_out` wires pass through `SYNC_DEPTH` sampling flops before the chain sees them. Per-stage `full` flags show where events are held. Per-stage `capture` pulses show where a bundled data register would latch.

Top module: `tpp_elastic_pipe`

## Requirements
- R1: Synchronous reset drives all stage outputs to 0. With reset asserted, `ack_in`, `req_out`, every `full` bit and every `capture` bit read 0.
- R2: A stage output changes only when its predecessor level differs from its successor level. It then takes the predecessor level. Otherwise it holds its value.
- R3: An event entering an empty pipeline reaches `ack_in` exactly SYNC_DEPTH+1 rising edges after `req_in` changes. It reaches `req_out` exactly SYNC_DEPTH+STAGES edges after that change, which is 2 and 4 edges with the defaults.
- R4: A falling transition on `req_in` is an event in the same way as a rising one. It is stored and counted separately from the event before it.
- R5: While no output acknowledge arrives, STAGES input transitions fill every stage and set all `full` bits. A further `req_in` transition is then not acknowledged, and `ack_in`, `full` and `capture` stay unchanged until space frees.
- R6: Each `ack_out` transition frees the last stage. The stored events then shift one stage toward the output per clock, and the event in the next stage appears on `req_out` two edges after the `ack_out` change.
- R7: `full[i]` is 1 exactly when the output of stage i differs from the output of stage i+1. For the last stage the comparison is with the sampled `ack_out`. Bit 0 is the stage nearest the input.
- R8: `capture[i]` is high for exactly one clock, in the cycle in which stage i shows its new output level, each time that output toggles. It is low otherwise.
- R9: Events leave on `req_out` in the order they entered. No event is lost or duplicated, and the pipeline drains to all `full` bits 0 with `req_out` equal to `ack_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 1 | Producer request; each toggle offers one event |
| ack_in | output | 1 | Acknowledge to producer; equals stage 0 output |
| req_out | output | 1 | Request to consumer; equals last stage output |
| ack_out | input | 1 | Consumer acknowledge; each toggle accepts one event |
| full | output | STAGES | Per-stage occupancy flags, bit 0 nearest the input |
| capture | output | STAGES | Per-stage one-cycle pulse on each output toggle |

## Verification
The bench builds the block with STAGES=3 and SYNC_DEPTH=1. With these values, three input transitions are enough to reach full occupancy, and a held fourth transition can be observed waiting at the input. The small depth also makes the exact 2-edge and 4-edge latencies and the shift of stored events after one output acknowledge easy to trace stage by stage. A randomized producer and consumer then run many events through the chain, and a scoreboard checks their order.

// File: rtl/tpp_pkg.sv
package tpp_pkg;

    // State held by one C-element stage: its output level and the
    // one-cycle strobe marking a fresh toggle of that level.
    typedef struct packed {
        logic lvl;
        logic cap;
    } tpp_stage_t;

endpackage

// File: rtl/tpp_sampler.sv
module tpp_sampler #(
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic req_raw,
    input  logic ack_raw,
    output logic req_s,
    output logic ack_s
);

    typedef struct packed {
        logic [DEPTH-1:0] req;
        logic [DEPTH-1:0] ack;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d        = smp_q;
        smp_d.req[0] = req_raw;
        smp_d.ack[0] = ack_raw;
        for (int i = 1; i < DEPTH; i++) begin
            smp_d.req[i] = smp_q.req[i-1];
            smp_d.ack[i] = smp_q.ack[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) smp_q <= '0;
        else     smp_q <= smp_d;
    end

    assign req_s = smp_q.req[DEPTH-1];
    assign ack_s = smp_q.ack[DEPTH-1];

    // R1: sampled wires start from 0 after reset
    p_sampler_reset_r1: assert property (@(posedge clk) rst |=> (req_s == 1'b0 && ack_s == 1'b0));

endmodule

// File: rtl/tpp_stage.sv
module tpp_stage (
    input  logic clk,
    input  logic rst,
    input  logic pred_i,
    input  logic succ_i,
    output logic lvl_o,
    output logic cap_o
);

    import tpp_pkg::*;

    tpp_stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // C-element: inputs are the predecessor and the inverted successor
        if (pred_i == !succ_i) begin
            st_d.lvl = pred_i;
        end
        st_d.cap = st_d.lvl ^ st_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;
    assign cap_o = st_q.cap;

    // R1: reset clears level and strobe
    p_stage_reset_r1: assert property (@(posedge clk) rst |=> (lvl_o == 1'b0 && cap_o == 1'b0));

    // R2: a change follows disagreeing neighbours and copies the predecessor
    p_fire_rule_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && lvl_o != $past(lvl_o)) |-> ($past(pred_i) != $past(succ_i) && lvl_o == $past(pred_i)));

    // R2: equal neighbour levels mean the stage holds
    p_hold_rule_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(pred_i) == $past(succ_i)) |-> $stable(lvl_o));

    // R8: strobe marks exactly the cycles with a new level
    p_cap_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cap_o == (lvl_o != $past(lvl_o))));

endmodule

// File: rtl/tpp_elastic_pipe.sv
module tpp_elastic_pipe #(
    parameter int STAGES     = 3,
    parameter int SYNC_DEPTH = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_in,
    output logic              ack_in,
    output logic              req_out,
    input  logic              ack_out,
    output logic [STAGES-1:0] full,
    output logic [STAGES-1:0] capture
);

    localparam int LAST = STAGES - 1;

    logic              req_s;
    logic              ack_s;
    logic [STAGES-1:0] lvl;
    logic [STAGES-1:0] pred_v;
    logic [STAGES-1:0] succ_v;

    tpp_sampler #(.DEPTH(SYNC_DEPTH)) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .req_raw (req_in),
        .ack_raw (ack_out),
        .req_s   (req_s),
        .ack_s   (ack_s)
    );

    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            pred_v[i] = (i == 0)    ? req_s : lvl[(i == 0) ? 0 : i-1];
            succ_v[i] = (i == LAST) ? ack_s : lvl[(i == LAST) ? LAST : i+1];
            full[i]   = lvl[i] ^ succ_v[i];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        tpp_stage u_stage (
            .clk    (clk),
            .rst    (rst),
            .pred_i (pred_v[g]),
            .succ_i (succ_v[g]),
            .lvl_o  (lvl[g]),
            .cap_o  (capture[g])
        );
    end

    assign ack_in  = lvl[0];
    assign req_out = lvl[LAST];

    // R1: no occupancy after reset
    p_full_reset_r1: assert property (@(posedge clk) rst |=> (full == '0));

    // R5: an occupied last stage keeps its request until acknowledged
    p_last_held_r5: assert property (@(posedge clk) disable iff (rst)
        full[LAST] |=> $stable(req_out));

    // R5: an occupied first stage refuses further input events
    p_first_held_r5: assert property (@(posedge clk) disable iff (rst)
        full[0] |=> $stable(ack_in));

endmodule

// File: tb/tb_tpp_elastic_pipe.sv
module tb_tpp_elastic_pipe;

    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_in = 1'b0;
    logic         ack_out = 1'b0;
    logic         ack_in;
    logic         req_out;
    logic [N-1:0] full;
    logic [N-1:0] capture;

    int   checks = 0;
    int   fails  = 0;
    logic expq[$];
    logic last_ro = 1'b0;

    always #5 clk = ~clk;

    tpp_elastic_pipe #(.STAGES(N), .SYNC_DEPTH(1)) dut (
        .clk     (clk),
        .rst     (rst),
        .req_in  (req_in),
        .ack_in  (ack_in),
        .req_out (req_out),
        .ack_out (ack_out),
        .full    (full),
        .capture (capture)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // driver: offer one event once the previous one is acknowledged
    task automatic send();
        while (ack_in !== req_in) @(negedge clk);
        req_in = ~req_in;
        expq.push_back(req_in);
    endtask

    // monitor: every req_out toggle must match the oldest pending event (R9)
    always @(negedge clk) begin
        if (!rst && req_out !== last_ro) begin
            if (expq.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R9: actual toggle to %0b expected no event", req_out);
            end else begin
                chk("R9 order", req_out, expq.pop_front());
            end
            last_ro = req_out;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 req_out", req_out, 0);
        chk("R1 ack_in", ack_in, 0);
        chk("R1 full", full, 0);
        chk("R1 capture", capture, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 full after release", full, 0);

        // R3 and R8: one event through the empty chain
        send();
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk("R8 capture walk", capture, (k == 1) ? 0 : (1 << (k - 2)));
            chk("R3 req_out latency", req_out, (k == 4) ? 1 : 0);
            chk("R3 ack_in latency", ack_in, (k >= 2) ? 1 : 0);
        end
        chk("R7 full one event", full, 3'b100);

        // R4: falling transition is its own event
        send();
        repeat (4) @(negedge clk);
        chk("R4 full two events", full, 3'b110);
        chk("R4 req_out still first", req_out, 1);
        chk("R4 ack_in", ack_in, 0);

        send();
        repeat (4) @(negedge clk);
        chk("R5 full all", full, 3'b111);
        chk("R5 ack_in third", ack_in, 1);

        // R5: fourth event waits at the input
        req_in = 1'b0;
        expq.push_back(1'b0);
        repeat (10) @(negedge clk);
        chk("R5 ack_in held", ack_in, 1);
        chk("R2 stage0 holds on disagreeing inputs", ack_in, 1);
        chk("R5 full held", full, 3'b111);
        chk("R5 req_out held", req_out, 1);
        chk("R5 capture quiet", capture, 0);

        // R6: one output acknowledge shifts the chain
        ack_out = 1'b1;
        @(negedge clk);
        chk("R6 last freed", full, 3'b011);
        @(negedge clk);
        chk("R6 req_out next", req_out, 0);
        chk("R6 capture last", capture, 3'b100);
        chk("R7 full mid shift", full, 3'b101);
        @(negedge clk);
        chk("R6 capture middle", capture, 3'b010);
        chk("R7 full shift", full, 3'b110);
        @(negedge clk);
        chk("R6 capture first", capture, 3'b001);
        chk("R6 fourth accepted", ack_in, 0);
        chk("R7 full refilled", full, 3'b111);

        // drain
        for (int i = 0; i < 8; i++) begin
            if (req_out !== ack_out) ack_out = ~ack_out;
            repeat (3) @(negedge clk);
        end
        chk("R7 drained full", full, 0);
        chk("R9 drained queue", expq.size(), 0);
        chk("R9 drained req_out", req_out, ack_out);

        // randomized streaming
        fork
            begin
                for (int i = 0; i < 24; i++) begin
                    repeat ($urandom_range(0, 3)) @(negedge clk);
                    send();
                end
            end
            begin
                int got = 0;
                while (got < 24) begin
                    @(negedge clk);
                    if (req_out !== ack_out) begin
                        repeat ($urandom_range(0, 2)) @(negedge clk);
                        ack_out = ~ack_out;
                        got++;
                    end
                end
            end
        join
        repeat (8) @(negedge clk);
        chk("R9 stream queue empty", expq.size(), 0);
        chk("R9 stream full clear", full, 0);
        chk("R9 stream ack_in", ack_in, req_in);
        report();
    end

endmodule